// File: doc/BRIEF.md
# Half-Bridge Interlock and Deadtime Sequencer

This block turns two logic commands into gate enables for the upper and lower switch of one half-bridge. The command for the lower switch is active low and the command for the upper switch is active high. A contradictory pair, where both switches are asked to conduct at once, turns both gates off. When a conducting request ends, the block holds both gates off for a programmable number of clock cycles before either gate may turn on again. Because of this, a single signal can drive both commands and still yield complementary gates with a guard gap.

Three inputs override the commands. A low on the halt input turns both gates off. A low on the lower-supply-good input also turns both gates off. A low on the floating-supply-good input turns off only the upper gate. All five control inputs pass through a parameterized synchronizer. The two gate outputs are registered.

Top module: `hb_gate_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, both `lo_gate` and `hi_gate` are 0.
- R2: When `halt_n` = 0, both gates are 0, whatever the commands are.
- R3: When `lo_cmd_n` = 0 and `hi_cmd` = 1, both gates are 0. `lo_gate` and `hi_gate` are never 1 together.
- R4: With no override active, the commands select the gates as follows. `lo_cmd_n` = 0 with `hi_cmd` = 0 requests the lower gate. `lo_cmd_n` = 1 with `hi_cmd` = 1 requests the upper gate. `lo_cmd_n` = 1 with `hi_cmd` = 0 requests neither gate.
- R5: With no guard interval pending, an input change appears at the gates on the (SYNC_STAGES+1)th rising edge after it is applied.
- R6: When the request leaves a conducting state, a guard interval starts. This includes a move straight to the other gate. For the next `dead_cycles`+1 cycles both gates are 0. A gate requested by then turns on exactly `dead_cycles`+1 cycles after the turn-off.
- R7: A request that arrives after the guard interval has already run out is passed to its gate with only the synchronizer latency of R5.
- R8: If the request leaves a conducting state again while a guard interval runs, the interval restarts from that change.
- R9: With `lo_cmd_n` and `hi_cmd` tied together, the gates are complementary. The gap described in R6 applies in both directions.
- R10: When `lo_supply_ok` = 0, both gates are 0.
- R11: When `hi_supply_ok` = 0, `hi_gate` is 0. `lo_gate` still follows its request.
- R12: A `dead_cycles` value of 0 gives a gap of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dead_cycles | input | DEAD_W | Guard interval length minus one, in clock cycles |
| lo_cmd_n | input | 1 | Lower switch command, active low |
| hi_cmd | input | 1 | Upper switch command, active high |
| halt_n | input | 1 | Halt, active low; forces both gates off |
| lo_supply_ok | input | 1 | Lower supply good; low forces both gates off |
| hi_supply_ok | input | 1 | Floating supply good; low forces the upper gate off |
| lo_gate | output | 1 | Lower switch gate enable |
| hi_gate | output | 1 | Upper switch gate enable |

## Verification
An input sampled at one rising edge takes effect at the gates SYNC_STAGES edges later. A turn-off edge arms the guard interval at that same edge. A newly requested gate then rises no earlier than `dead_cycles`+1 edges after the arming edge. The bench drives its inputs 2 ns after a rising edge and checks the gates 2 ns after every edge. Its model delays the decoded request by SYNC_STAGES edges and records the edge at which the last interval was armed. The tied-command checks count those edge offsets literally, so a gate that rises one edge early or late is caught.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_LO   = 2'd1,
    REQ_HI   = 2'd2
  } req_t;
endpackage

// File: rtl/hb_input_sync.sv
`timescale 1ns/1ps
module hb_input_sync #(
  parameter int               STAGES  = 2,
  parameter int               W       = 5,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else if (i == 0) stg[i] <= d;
          else stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hb_req_decode.sv
`timescale 1ns/1ps
module hb_req_decode
  import hb_pkg::*;
(
  input  logic lo_cmd_n,
  input  logic hi_cmd,
  input  logic halt_n,
  input  logic lo_supply_ok,
  input  logic hi_supply_ok,
  output req_t req
);
  logic want_lo, want_hi, allowed;

  always_comb begin
    want_lo = !lo_cmd_n;
    want_hi = hi_cmd;
    allowed = halt_n && lo_supply_ok;
    req     = REQ_NONE;
    if (allowed) begin
      if (want_lo && !want_hi)                     req = REQ_LO;
      else if (want_hi && !want_lo && hi_supply_ok) req = REQ_HI;
    end
  end
endmodule

// File: rtl/hb_dead_timer.sv
`timescale 1ns/1ps
module hb_dead_timer
  import hb_pkg::*;
#(
  parameter int DEAD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEAD_W-1:0] dead_cycles,
  input  req_t              req,
  output logic              lo_gate,
  output logic              hi_gate
);
  localparam int CNT_W = DEAD_W + 1;

  req_t             req_q;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             arm;

  always_comb begin
    arm = (req != req_q) && (req_q != REQ_NONE);
    if (arm)            cnt_nx = {1'b0, dead_cycles} + CNT_W'(1);
    else if (cnt != '0) cnt_nx = cnt - CNT_W'(1);
    else                cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= REQ_NONE;
      cnt     <= '0;
      lo_gate <= 1'b0;
      hi_gate <= 1'b0;
    end else begin
      req_q   <= req;
      cnt     <= cnt_nx;
      lo_gate <= (req == REQ_LO) && (cnt_nx == '0);
      hi_gate <= (req == REQ_HI) && (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/hb_gate_sequencer.sv
`timescale 1ns/1ps
module hb_gate_sequencer
  import hb_pkg::*;
#(
  parameter int DEAD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEAD_W-1:0] dead_cycles,
  input  logic              lo_cmd_n,
  input  logic              hi_cmd,
  input  logic              halt_n,
  input  logic              lo_supply_ok,
  input  logic              hi_supply_ok,
  output logic              lo_gate,
  output logic              hi_gate
);
  localparam int          NIN      = 5;
  localparam logic [NIN-1:0] SAFE_VAL = 5'b0_0_0_1_0;

  logic [NIN-1:0] raw, syn;
  req_t           req;

  assign raw = {halt_n, lo_supply_ok, hi_supply_ok, lo_cmd_n, hi_cmd};

  hb_input_sync #(.STAGES(SYNC_STAGES), .W(NIN), .RST_VAL(SAFE_VAL)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  hb_req_decode u_dec (
    .halt_n(syn[4]), .lo_supply_ok(syn[3]), .hi_supply_ok(syn[2]),
    .lo_cmd_n(syn[1]), .hi_cmd(syn[0]), .req(req)
  );

  hb_dead_timer #(.DEAD_W(DEAD_W)) u_timer (
    .clk(clk), .rst(rst), .dead_cycles(dead_cycles), .req(req),
    .lo_gate(lo_gate), .hi_gate(hi_gate)
  );
endmodule

// File: rtl/hb_gate_sequencer_chk.sv
`timescale 1ns/1ps
module hb_gate_sequencer_chk #(
  parameter int STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic halt_n,
  input logic lo_supply_ok,
  input logic hi_supply_ok,
  input logic lo_gate,
  input logic hi_gate
);
  localparam int CW = $clog2(STAGES + 2) + 1;
  localparam logic [CW-1:0] LIM = CW'(STAGES + 1);

  logic [CW-1:0] halt_run, losup_run, hisup_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_run  <= '0;
      losup_run <= '0;
      hisup_run <= '0;
    end else begin
      halt_run  <= halt_n       ? '0 : ((halt_run  == LIM) ? LIM : halt_run  + 1'b1);
      losup_run <= lo_supply_ok ? '0 : ((losup_run == LIM) ? LIM : losup_run + 1'b1);
      hisup_run <= hi_supply_ok ? '0 : ((hisup_run == LIM) ? LIM : hisup_run + 1'b1);
    end
  end

  AST_NO_OVERLAP:    assert property (@(posedge clk) disable iff (rst) !(lo_gate && hi_gate)); // R3
  AST_GAP_LO_TO_HI:  assert property (@(posedge clk) disable iff (rst) $rose(hi_gate) |-> !$past(lo_gate)); // R6
  AST_GAP_HI_TO_LO:  assert property (@(posedge clk) disable iff (rst) $rose(lo_gate) |-> !$past(hi_gate)); // R6
  AST_HALT_OFF:      assert property (@(posedge clk) disable iff (rst) (halt_run == LIM) |-> (!lo_gate && !hi_gate)); // R2
  AST_LO_SUPPLY_OFF: assert property (@(posedge clk) disable iff (rst) (losup_run == LIM) |-> (!lo_gate && !hi_gate)); // R10
  AST_HI_SUPPLY_OFF: assert property (@(posedge clk) disable iff (rst) (hisup_run == LIM) |-> !hi_gate); // R11
endmodule

bind hb_gate_sequencer hb_gate_sequencer_chk #(.STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .halt_n(halt_n), .lo_supply_ok(lo_supply_ok),
  .hi_supply_ok(hi_supply_ok), .lo_gate(lo_gate), .hi_gate(hi_gate)
);

// File: tb/hb_gate_sequencer_tb.sv
`timescale 1ns/1ps
module hb_gate_sequencer_tb;
  localparam int DW = 16;
  localparam int S  = 2;
  localparam int NONE = 0, LO = 1, HI = 2;

  logic clk = 0, rst = 1;
  logic [DW-1:0] dead_cycles = '0;
  logic lo_cmd_n = 1, hi_cmd = 0, halt_n = 0, lo_supply_ok = 0, hi_supply_ok = 0;
  logic lo_gate, hi_gate;

  int checks = 0, fails = 0;
  bit done = 0;
  int dly [S+1];
  int e, last_arm, rprev, D;

  always #5 clk = ~clk;

  hb_gate_sequencer #(.DEAD_W(DW), .SYNC_STAGES(S)) u_dut (
    .clk(clk), .rst(rst), .dead_cycles(dead_cycles), .lo_cmd_n(lo_cmd_n),
    .hi_cmd(hi_cmd), .halt_n(halt_n), .lo_supply_ok(lo_supply_ok),
    .hi_supply_ok(hi_supply_ok), .lo_gate(lo_gate), .hi_gate(hi_gate)
  );

  function automatic int want(logic ln, logic h, logic hn, logic lok, logic hok);
    if (!hn || !lok) return NONE;
    if (!ln && !h) return LO;
    if (ln && h && hok) return HI;
    return NONE;
  endfunction

  task automatic chk(logic got_lo, logic got_hi, logic exp_lo, logic exp_hi, string tag);
    checks++;
    if (got_lo !== exp_lo || got_hi !== exp_hi) begin
      fails++;
      $display("FAIL %s: got lo=%0b hi=%0b, expected lo=%0b hi=%0b (t=%0t)",
               tag, got_lo, got_hi, exp_lo, exp_hi, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i <= S; i++) dly[i] = NONE;
    e = 0; last_arm = -1000000; rprev = NONE;
  endtask

  task automatic set_in(logic [4:0] v);
    {halt_n, lo_supply_ok, hi_supply_ok, lo_cmd_n, hi_cmd} = v;
  endtask

  // one clock edge: model update and compare against model
  task automatic step(string tag);
    int r;
    logic el, eh;
    @(posedge clk); #2;
    e++;
    for (int i = S; i > 0; i--) dly[i] = dly[i-1];
    dly[0] = want(lo_cmd_n, hi_cmd, halt_n, lo_supply_ok, hi_supply_ok);
    r = dly[S];
    if (r != rprev && rprev != NONE) last_arm = e;
    rprev = r;
    el = (r == LO) && ((e - last_arm) >= D + 1);
    eh = (r == HI) && ((e - last_arm) >= D + 1);
    chk(lo_gate, hi_gate, el, eh, tag);
  endtask

  task automatic idle(int n, string tag);
    set_in(5'b11110);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // tied commands: literal edge counting
  task automatic tied_swap(logic to_hi, string tag);
    set_in(to_hi ? 5'b11111 : 5'b11100);
    for (int k = 1; k <= S + D + 2; k++) begin
      logic el, eh;
      step(tag);
      el = to_hi ? (k <= S) : (k == S + D + 2);
      eh = to_hi ? (k == S + D + 2) : (k <= S);
      chk(lo_gate, hi_gate, el, eh, tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hang, expected completion");
    finish_run();
  end

  initial begin
    D = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    chk(lo_gate, hi_gate, 1'b0, 1'b0, "R1 reset");
    set_in(5'b11100);
    rst = 0;
    step("R1 first cycle");

    // R4 / R5: lower request after reset
    for (int i = 0; i < 4; i++) step("R4 R5 low request");
    // R9 / R12: tied commands with zero count
    tied_swap(1'b1, "R9 R12 low to high D=0");
    for (int i = 0; i < 3; i++) step("R4 high hold");
    tied_swap(1'b0, "R9 R12 high to low D=0");

    // R6 / R9 with a longer interval
    idle(4, "R4 idle"); dead_cycles = 16'd3; D = 3;
    set_in(5'b11100); for (int i = 0; i < 6; i++) step("R4 low");
    tied_swap(1'b1, "R6 R9 low to high D=3");
    tied_swap(1'b0, "R6 R9 high to low D=3");

    // R7: request after interval expired
    idle(D + 1, "R7 gap");
    set_in(5'b11111);
    for (int k = 1; k <= S + 1; k++) begin
      step("R7 direct");
      chk(lo_gate, hi_gate, 1'b0, k == S + 1, "R7 direct literal");
    end

    // R8: bounce within interval
    set_in(5'b11100); step("R8 bounce");
    set_in(5'b11111); step("R8 bounce");
    set_in(5'b11100); for (int i = 0; i < D + S + 4; i++) step("R8 restart");

    // R2, R10, R11 overrides
    set_in(5'b01100); for (int i = 0; i < S + 2; i++) step("R2 halt");
    set_in(5'b10100); for (int i = 0; i < S + 2; i++) step("R10 low supply");
    set_in(5'b11000); for (int i = 0; i < D + S + 3; i++) step("R11 low still on");
    set_in(5'b11011); for (int i = 0; i < D + S + 3; i++) step("R11 high blocked");
    set_in(5'b11101); for (int i = 0; i < D + S + 3; i++) step("R3 contradiction");

    // exhaustive pair sweep over several interval lengths
    foreach (dly[i]) ; 
    for (int di = 0; di < 4; di++) begin
      int dv;
      dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 3 : 6;
      idle(D + S + 3, "R6 settle");
      dead_cycles = DW'(dv); D = dv;
      idle(2, "R6 settle");
      for (int a = 0; a < 32; a++) begin
        for (int b = 0; b < 32; b++) begin
          set_in(5'(a));
          for (int h = 0; h < 1 + ((a * 7 + b) % (D + 4)); h++) step("R2/R3/R4/R6/R7/R8/R10/R11 sweep");
          set_in(5'(b));
          for (int h = 0; h < 1 + ((a + b * 5) % (D + 4)); h++) step("R2/R3/R4/R6/R7/R8/R10/R11 sweep");
        end
      end
    end
    finish_run();
  end
endmodule